// File: doc/BRIEF.md
# Host Bus DMA FIFO Interface

This block sits between a host processor bus with a DMA controller and the data path of a peripheral transfer engine. A byte-wide FIFO carries the transfer data. The host reaches the FIFO, a control register and an interrupt status register through chip-select cycles. The DMA controller reaches the FIFO alone through acknowledge cycles. The peripheral side fills or drains the FIFO through a simple push/pop port. Which side pushes and which side pops is set by a direction bit.

The block drives a DMA request. It is modelled as an output enable and a value, and it is released whenever DMA is disabled. In the normal mode the request asks for a single byte at a time. In burst mode it waits until eight bytes of data or space are available. It also drives an active-low interrupt. Overflow, underflow, a bus reset event or a peripheral event set the interrupt. There is no mask. Only a status read, a hardware reset or a software reset command clears it.

Host strobes are sampled on every rising clock edge. Each cycle in which a strobe is low counts as one access. Read data is valid during the cycle of the read.

Top module: `hbdma_if`

## Requirements
- R1: While `rst` is high and after it falls, the FIFO is empty (`fifo_count`=0), `irq_n`=1, `dreq_oe`=0, `dreq_val`=0, and the control register reads 0.
- R2: A register write takes place only in a cycle with both `cs_n`=0 and `wr_n`=0. A write strobe without chip select leaves the control register unchanged.
- R3: With `dack_n`=0 an access always targets the FIFO data port, whatever `addr` holds. With `cs_n`=0 and `dack_n`=1, `addr` selects the register: 0 is control, 1 is FIFO data and 2 is interrupt status. Control bits are bit0 DMA enable, bit1 direction (1 = toward memory), bit2 burst-eight enable and bit3 reset command. Control reads return {5'b0, burst, dir, enable}.
- R4: The FIFO holds 16 bytes in first-in first-out order. `fifo_count`, `fifo_full` and `fifo_empty` track its fill level.
- R5: A push into a full FIFO with no pop in the same cycle is dropped and sets status bit0. A pop from an empty FIFO is ignored and sets status bit1.
- R6: With direction 1 the peripheral pushes and the host pops. With direction 0 the host pushes and the peripheral pops. A host or peripheral FIFO access against the direction has no effect, and a host read of that kind returns 0.
- R7: With DMA enabled, direction 1 and burst mode off, `dreq_val`=1 exactly when the FIFO holds at least one byte.
- R8: With DMA enabled, direction 0 and burst mode off, `dreq_val`=1 exactly when the FIFO has room for at least one byte.
- R9: In burst mode, `dreq_val`=1 only when at least 8 bytes (direction 1) or 8 free slots (direction 0) are present.
- R10: With DMA disabled, `dreq_oe`=0 and `dreq_val`=0.
- R11: An interrupt event drives `irq_n` low from the next rising edge. Status bits are bit0 overflow, bit1 underflow, bit2 bus reset (`bus_rst`) and bit3 peripheral event (`per_evt`).
- R12: Reading the status register returns the pending bits and clears them. An event in the same cycle as the read survives the clear.
- R13: No mask exists and a bus reset event never clears the interrupt. Only a status read, `rst` or the reset command clears it.
- R14: Writing control with bit3 set empties the FIFO, clears status and interrupt, and zeroes the control register from the next edge. Events in that cycle are dropped, and bit3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high hardware reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dack_n | input | 1 | Active-low DMA acknowledge |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is selected |
| dreq_oe | output | 1 | DMA request drive enable |
| dreq_val | output | 1 | DMA request level |
| irq_n | output | 1 | Active-low interrupt, 1 means released |
| per_push | input | 1 | Peripheral push strobe |
| per_wdata | input | 8 | Peripheral push data |
| per_pop | input | 1 | Peripheral pop strobe |
| per_rdata | output | 8 | FIFO head byte seen by the peripheral |
| per_evt | input | 1 | Peripheral interrupt event |
| bus_rst | input | 1 | Bus reset event |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_count | output | 5 | FIFO fill level |

## Verification
Assertions check several rules on every cycle. The request level is checked against the fill level in each mode. The FIFO count is checked to stay bounded and to grow on a push. Writes without chip select, or under acknowledge, are checked to leave control untouched. The interrupt is checked to follow events and to stay asserted until a read or a reset. The bench scenarios cover behaviour that needs a full sequence: byte ordering across a full fill and drain, error bit encodings seen through status reads, accesses that the direction blocks, the race between a read and a new event, and the effect of the reset command on every piece of state.

// File: rtl/hbdma_pkg.sv
package hbdma_pkg;
  // register selects
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;

  // control bits
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_THR  = 2;
  localparam int CB_SRST = 3;

  // status bits
  localparam int SB_OVF  = 0;
  localparam int SB_UNF  = 1;
  localparam int SB_BRST = 2;
  localparam int SB_PEVT = 3;
  localparam int NSTAT   = 4;

  // request rule: data available toward memory, space available from memory
  function automatic logic dreq_wanted(int unsigned count, int unsigned depth,
                                       logic to_mem, logic burst, int unsigned blen);
    int unsigned need;
    need = burst ? blen : 1;
    if (to_mem) return count >= need;
    return (depth - count) >= need;
  endfunction
endpackage

// File: rtl/hbdma_fifo.sv
module hbdma_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       ovf_evt,
  output logic                       unf_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign ovf_evt = push & ~do_push;
  assign unf_evt = pop & empty;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_push_grow_R4: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop && !clr) |=> (count == $past(count) + 1'b1));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/hbdma_dreq.sv
module hbdma_dreq #(
  parameter int DEPTH = 16,
  parameter int BLEN  = 8
) (
  input  logic                       en,
  input  logic                       to_mem,
  input  logic                       burst,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       oe,
  output logic                       val
);
  import hbdma_pkg::*;

  assign oe  = en;
  assign val = en & dreq_wanted(int'(count), DEPTH, to_mem, burst, BLEN);
endmodule

// File: rtl/hbdma_irq.sv
module hbdma_irq #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rd_clr,
  input  logic [NS-1:0] evt,
  output logic [NS-1:0] stat,
  output logic          irq_n
);
  logic [NS-1:0] stat_nxt;

  // new events win over a clearing read in the same cycle
  assign stat_nxt = (rd_clr ? '0 : stat) | evt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stat  <= '0;
      irq_n <= 1'b1;
    end else begin
      stat  <= stat_nxt;
      irq_n <= ~(|stat_nxt);
    end
  end

  assert_evt_irq_R11: assert property (@(posedge clk) disable iff (rst)
    ((|evt) && !clr) |=> !irq_n);
  assert_rd_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|evt) && !clr) |=> irq_n);
  assert_no_mask_R13: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !rd_clr && !clr) |=> !irq_n);
endmodule

// File: rtl/hbdma_if.sv
module hbdma_if #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int BLEN   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic                       dack_n,
  input  logic [1:0]                 addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       dreq_oe,
  output logic                       dreq_val,
  output logic                       irq_n,
  input  logic                       per_push,
  input  logic [DATA_W-1:0]          per_wdata,
  input  logic                       per_pop,
  output logic [DATA_W-1:0]          per_rdata,
  input  logic                       per_evt,
  input  logic                       bus_rst,
  output logic                       fifo_full,
  output logic                       fifo_empty,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  import hbdma_pkg::*;

  logic dma_en, to_mem, burst8;
  logic host_wr, host_rd, fifo_sel, ctrl_sel, stat_sel;
  logic ctrl_wr, soft_rst, rd_clr;
  logic f_push, f_pop, ovf_evt, unf_evt;
  logic [DATA_W-1:0] f_wdata, head;
  logic [NSTAT-1:0]  evt, stat;

  // access decode: acknowledge reaches the data port only
  assign host_wr  = ~wr_n;
  assign host_rd  = ~rd_n & wr_n;
  assign fifo_sel = ~dack_n | (~cs_n & (addr == ADR_DATA));
  assign ctrl_sel = dack_n & ~cs_n & (addr == ADR_CTRL);
  assign stat_sel = dack_n & ~cs_n & (addr == ADR_STAT);
  assign ctrl_wr  = ctrl_sel & host_wr;
  assign soft_rst = ctrl_wr & wdata[CB_SRST];
  assign rd_clr   = stat_sel & host_rd;

  // direction picks the pushing and popping side
  assign f_push  = to_mem ? per_push : (fifo_sel & host_wr);
  assign f_pop   = to_mem ? (fifo_sel & host_rd) : per_pop;
  assign f_wdata = to_mem ? per_wdata : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en <= 1'b0;
      to_mem <= 1'b0;
      burst8 <= 1'b0;
    end else if (ctrl_wr) begin
      if (wdata[CB_SRST]) begin
        dma_en <= 1'b0;
        to_mem <= 1'b0;
        burst8 <= 1'b0;
      end else begin
        dma_en <= wdata[CB_EN];
        to_mem <= wdata[CB_DIR];
        burst8 <= wdata[CB_THR];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (host_rd) begin
      if (fifo_sel && to_mem) rdata = head;
      else if (ctrl_sel) begin
        rdata[CB_EN]  = dma_en;
        rdata[CB_DIR] = to_mem;
        rdata[CB_THR] = burst8;
      end else if (stat_sel) rdata[NSTAT-1:0] = stat;
    end
  end

  always_comb begin
    evt          = '0;
    evt[SB_OVF]  = ovf_evt;
    evt[SB_UNF]  = unf_evt;
    evt[SB_BRST] = bus_rst;
    evt[SB_PEVT] = per_evt;
  end

  assign per_rdata = head;

  hbdma_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(soft_rst), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .head(head), .count(fifo_count), .full(fifo_full),
    .empty(fifo_empty), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  hbdma_dreq #(.DEPTH(DEPTH), .BLEN(BLEN)) u_dreq (
    .en(dma_en), .to_mem(to_mem), .burst(burst8), .count(fifo_count),
    .oe(dreq_oe), .val(dreq_val)
  );

  hbdma_irq #(.NS(NSTAT)) u_irq (
    .clk(clk), .rst(rst), .clr(soft_rst), .rd_clr(rd_clr), .evt(evt),
    .stat(stat), .irq_n(irq_n)
  );

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n || wr_n) |=> $stable({dma_en, to_mem, burst8}));
  assert_dack_only_R3: assert property (@(posedge clk) disable iff (rst)
    !dack_n |=> $stable({dma_en, to_mem, burst8}));
  assert_dreq_tomem_R7: assert property (@(posedge clk) disable iff (rst)
    (dma_en && to_mem && !burst8 && !fifo_empty) |-> dreq_val);
  assert_dreq_frommem_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_en && !to_mem && !burst8 && fifo_full) |-> !dreq_val);
  assert_dreq_burst_R9: assert property (@(posedge clk) disable iff (rst)
    (dma_en && to_mem && burst8 && (fifo_count < BLEN)) |-> !dreq_val);
  assert_dreq_off_R10: assert property (@(posedge clk) disable iff (rst)
    !dma_en |-> (!dreq_oe && !dreq_val));
  assert_srst_R14: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (fifo_empty && irq_n && !dma_en));
endmodule

// File: tb/hbdma_if_bench.sv
`timescale 1ns/1ps
module hbdma_if_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, per_wdata = 8'h00;
  logic per_push = 1'b0, per_pop = 1'b0, per_evt = 1'b0, bus_rst = 1'b0;
  logic [7:0] rdata, per_rdata;
  logic dreq_oe, dreq_val, irq_n, fifo_full, fifo_empty;
  logic [4:0] fifo_count;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  hbdma_if u_hbdma_if (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dreq_oe(dreq_oe), .dreq_val(dreq_val),
    .irq_n(irq_n), .per_push(per_push), .per_wdata(per_wdata), .per_pop(per_pop),
    .per_rdata(per_rdata), .per_evt(per_evt), .bus_rst(bus_rst), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count)
  );

  // {dir, burst, count[4:0], expected request}
  localparam logic [7:0] VEC [10] = '{
    {1'b1, 1'b0, 5'd0,  1'b0}, {1'b1, 1'b0, 5'd1,  1'b1},
    {1'b1, 1'b1, 5'd7,  1'b0}, {1'b1, 1'b1, 5'd8,  1'b1},
    {1'b0, 1'b0, 5'd15, 1'b1}, {1'b0, 1'b0, 5'd16, 1'b0},
    {1'b0, 1'b1, 5'd8,  1'b1}, {1'b0, 1'b1, 5'd9,  1'b0},
    {1'b0, 1'b1, 5'd0,  1'b1}, {1'b1, 1'b1, 5'd16, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic hwrite(logic [1:0] a, logic [7:0] d);
    cs_n = 0; wr_n = 0; addr = a; wdata = d;
    tick();
    cs_n = 1; wr_n = 1;
  endtask

  task automatic hread(logic [1:0] a, output logic [7:0] d);
    cs_n = 0; rd_n = 0; addr = a;
    #2 d = rdata;
    tick();
    cs_n = 1; rd_n = 1;
  endtask

  task automatic dwrite(logic [1:0] a, logic [7:0] d);
    dack_n = 0; wr_n = 0; addr = a; wdata = d;
    tick();
    dack_n = 1; wr_n = 1;
  endtask

  task automatic ppush(logic [7:0] d);
    per_push = 1; per_wdata = d;
    tick();
    per_push = 0;
  endtask

  task automatic ppop(output logic [7:0] d);
    per_pop = 1;
    #2 d = per_rdata;
    tick();
    per_pop = 0;
  endtask

  task automatic soft_reset();
    hwrite(2'd0, 8'h08);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(); tick(); tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 count", fifo_count, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 irq_n", irq_n, 1);
    check("R1 dreq_oe", dreq_oe, 0);
    hread(2'd0, d);
    check("R1 ctrl", d, 0);

    // table walk: request level by direction, mode and fill (R7 R8 R9)
    for (int i = 0; i < 10; i++) begin
      logic vdir, vthr, vexp;
      int vcnt;
      vdir = VEC[i][7]; vthr = VEC[i][6]; vcnt = int'(VEC[i][5:1]); vexp = VEC[i][0];
      soft_reset();
      hwrite(2'd0, {5'b0, vthr, vdir, 1'b1});
      for (int k = 0; k < vcnt; k++) begin
        if (vdir) ppush(8'(k)); else dwrite(2'd1, 8'(k));
      end
      check("R4 fill count", fifo_count, vcnt);
      check("R10 oe on", dreq_oe, 1);
      if (vthr) check("R9 dreq", dreq_val, vexp);
      else if (vdir) check("R7 dreq", dreq_val, vexp);
      else check("R8 dreq", dreq_val, vexp);
    end

    // R4 ordering, from memory: host pushes through DACK, peripheral pops
    soft_reset();
    hwrite(2'd0, 8'h00);
    for (int k = 0; k < 16; k++) dwrite(2'd1, 8'(k * 3 + 1));
    check("R4 full", fifo_full, 1);
    for (int k = 0; k < 16; k++) begin
      ppop(d);
      check("R4 order", d, k * 3 + 1);
    end
    check("R4 empty", fifo_empty, 1);

    // R10 disabled request with data present
    dwrite(2'd1, 8'hAA);
    check("R10 oe off", dreq_oe, 0);
    check("R10 val off", dreq_val, 0);

    // R5 overflow then underflow
    soft_reset();
    for (int k = 0; k < 17; k++) dwrite(2'd1, 8'(k));
    check("R5 count held", fifo_count, 16);
    check("R11 irq after ovf", irq_n, 0);
    hread(2'd2, d);
    check("R5 ovf bit", d, 8'h01);
    check("R12 irq cleared", irq_n, 1);
    for (int k = 0; k < 16; k++) ppop(d);
    check("R5 last data", d, 15);
    ppop(d);
    check("R5 empty held", fifo_count, 0);
    hread(2'd2, d);
    check("R5 unf bit", d, 8'h02);

    // R2 write strobe without chip select
    hwrite(2'd0, 8'h01);
    cs_n = 1; wr_n = 0; addr = 2'd0; wdata = 8'h06;
    tick();
    wr_n = 1;
    hread(2'd0, d);
    check("R2 ctrl kept", d, 8'h01);

    // R3 acknowledge ignores addr
    soft_reset();
    hwrite(2'd0, 8'h01);
    dwrite(2'd0, 8'h55);
    check("R3 dack addr0 push", fifo_count, 1);
    hread(2'd0, d);
    check("R3 ctrl untouched", d, 8'h01);
    dwrite(2'd2, 8'h66);
    check("R3 dack addr2 push", fifo_count, 2);
    check("R3 irq untouched", irq_n, 1);

    // R6 accesses against the direction
    hread(2'd1, d);
    check("R6 host read dir0 data", d, 0);
    check("R6 host read dir0 count", fifo_count, 2);
    ppush(8'h77);
    check("R6 per push dir0", fifo_count, 2);
    hwrite(2'd0, 8'h03);
    dwrite(2'd1, 8'h11);
    check("R6 dack write dir1", fifo_count, 2);
    ppop(d);
    check("R6 per pop dir1", fifo_count, 2);
    hread(2'd1, d);
    check("R6 host read dir1", d, 8'h55);
    check("R6 host pop count", fifo_count, 1);

    // R11 peripheral event
    soft_reset();
    per_evt = 1; tick(); per_evt = 0;
    check("R11 irq low", irq_n, 0);
    hread(2'd2, d);
    check("R11 pevt bit", d, 8'h08);

    // R12 read racing a new event
    bus_rst = 1; tick(); bus_rst = 0;
    per_evt = 1;
    hread(2'd2, d);
    per_evt = 0;
    check("R12 read value", d, 8'h04);
    check("R12 irq kept", irq_n, 0);
    hread(2'd2, d);
    check("R12 new event kept", d, 8'h08);
    check("R12 irq released", irq_n, 1);

    // R13 bus reset never clears, no mask
    bus_rst = 1; tick(); tick(); bus_rst = 0;
    repeat (5) tick();
    check("R13 irq held", irq_n, 0);
    rst = 1; tick(); tick(); rst = 0; tick();
    check("R13 hw reset clears", irq_n, 1);

    // R14 reset command
    hwrite(2'd0, 8'h05);
    dwrite(2'd1, 8'h12);
    per_evt = 1; tick(); per_evt = 0;
    check("R14 pre irq", irq_n, 0);
    soft_reset();
    check("R14 count", fifo_count, 0);
    check("R14 irq", irq_n, 1);
    hread(2'd0, d);
    check("R14 ctrl", d, 0);
    hread(2'd2, d);
    check("R14 status", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule